// File: doc/BRIEF.md
# Redundant Receive Lane Selector and Liveness Monitor

This block sits in front of a serial receiver that owns two redundant incoming lanes. One lane is sent to the clock-recovery and data path. The other lane goes to an activity monitor, which reports whether that spare lane is still carrying traffic. A select input sets which lane does which job. A loopback control replaces both lanes with the local transmit bit stream, so the link can be tested without the backplane. Clock recovery itself is not part of this block.

The activity monitor works on word periods of 34 bit clocks. An external word strobe marks the last bit of each period. During a period the monitor keeps a sticky flag that sets on any transition of the monitored bit. At the strobe it copies that flag into the alive output and then clears the flag.

Some periods are not complete. The partial period after reset, and the partial period in which the select or loopback control changes, are thrown away. Alive is therefore reported low until a whole, undisturbed period has been seen. Firmware or a supervisor reads alive as a slow status bit to decide whether switching over to the spare lane is safe.

Top module: `lane_watch_top`

## Requirements
- R1: With the select input low and loopback low, `data_bit_o` equals `lane_a_i` and `mon_bit_o` equals `lane_b_i` in the same cycle (combinational path).
- R2: With the select input high and loopback low, `data_bit_o` equals `lane_b_i` and `mon_bit_o` equals `lane_a_i`.
- R3: With loopback high, both `data_bit_o` and `mon_bit_o` equal `tx_loop_i`, whatever the select input is.
- R4: At a word strobe that closes a whole, undisturbed period in which the monitored bit changed at least once, `alive_o` is high from the following clock edge.
- R5: At a word strobe that closes a whole period with no change on the monitored bit, `alive_o` is low from the following clock edge.
- R6: `alive_o` changes only at a clock edge whose cycle carried the word strobe or a control change. The strobe is high for one cycle in every 34.
- R7: While reset (active high, synchronous) is asserted, `alive_o` is low. After release, the partial period up to the first strobe is discarded, so `alive_o` stays low at least until the end of the first whole period.
- R8: A change on the select or loopback input drives `alive_o` low from the next edge. The step in the monitored bit caused by the rerouting is not counted as a transition. The partial period in which the change happens is discarded, so the earliest high is at the end of the next whole period.
- R9: A transition between the last bit of one period and the first bit of the next counts toward the later period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_a_i | input | 1 | Serial bit of redundant lane A |
| lane_b_i | input | 1 | Serial bit of redundant lane B |
| tx_loop_i | input | 1 | Local transmit serial bit, used in loopback |
| sel_b_i | input | 1 | 0: A to data path, B to monitor; 1: crossed |
| loop_en_i | input | 1 | 1: transmit stream feeds both outputs |
| word_end_i | input | 1 | High on the last bit of each 34-bit word |
| data_bit_o | output | 1 | Bit sent to the recovery and data path |
| mon_bit_o | output | 1 | Bit sent to the activity monitor |
| alive_o | output | 1 | Monitored lane showed activity in the last whole period |

## Verification
The assertions assume that the word strobe arrives exactly once every 34 clocks, starting with the first period after reset is released. They also assume the controls are sampled on the bit clock, so a control change lands in one clock cycle. The bench keeps to both assumptions:
- It derives the strobe from a phase counter that restarts at reset.
- It changes the controls and lane data only on the falling clock edge.

It drives many lane patterns: random, toggling, stuck, one change per word exactly at the word boundary, and a mid-word pulse. It also changes controls at arbitrary phases, including two changes inside one period.

// File: rtl/lw_pkg.sv
package lw_pkg;

    // Routing controls as sampled on the bit clock.
    typedef struct packed {
        logic loop_en;
        logic sel_b;
    } lw_route_t;

    // Edge detector state: previous monitored bit, and whether it is valid.
    typedef struct packed {
        logic prev;
        logic armed;
    } lw_edge_st_t;

    // Liveness tracker state.
    typedef struct packed {
        logic seen;   // transition seen in the current period
        logic skip;   // current period is partial and must be discarded
        logic alive;  // registered liveness result
    } lw_live_st_t;

endpackage

// File: rtl/lw_lane_steer.sv
module lw_lane_steer
    import lw_pkg::*;
(
    input  logic      lane_a_i,
    input  logic      lane_b_i,
    input  logic      tx_loop_i,
    input  lw_route_t route_i,
    output logic      data_bit_o,
    output logic      mon_bit_o
);

    // Crossed routing: the lane that is not feeding data is the one watched.
    always_comb begin
        if (route_i.loop_en) begin
            data_bit_o = tx_loop_i;
            mon_bit_o  = tx_loop_i;
        end else if (route_i.sel_b) begin
            data_bit_o = lane_b_i;
            mon_bit_o  = lane_a_i;
        end else begin
            data_bit_o = lane_a_i;
            mon_bit_o  = lane_b_i;
        end
    end

endmodule

// File: rtl/lw_ctrl_watch.sv
module lw_ctrl_watch
    import lw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lw_route_t route_i,
    output logic      chg_o
);

    lw_route_t route_d, route_q;

    // The register follows the controls even during reset, so the first
    // cycle after release does not report a false change.
    always_comb begin
        route_d = route_i;
        chg_o   = !rst && (route_i != route_q);
    end

    always_ff @(posedge clk) begin
        route_q <= route_d;
    end

endmodule

// File: rtl/lw_edge_detect.sv
module lw_edge_detect
    import lw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_i,
    input  logic mask_i,
    output logic edge_o
);

    lw_edge_st_t st_d, st_q;

    always_comb begin
        st_d.prev  = bit_i;
        st_d.armed = 1'b1;
        if (rst) begin
            st_d.armed = 1'b0;
        end
        // A masked cycle (rerouting) never reports a transition.
        edge_o = st_q.armed && !mask_i && (bit_i != st_q.prev);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/lw_live_track.sv
module lw_live_track
    import lw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    input  logic restart_i,
    input  logic word_end_i,
    output logic alive_o
);

    lw_live_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.seen  = 1'b0;
            st_d.skip  = 1'b1;
            st_d.alive = 1'b0;
        end else if (restart_i) begin
            // Control change: drop the result and the partial period.
            st_d.seen  = 1'b0;
            st_d.skip  = 1'b1;
            st_d.alive = 1'b0;
        end else if (word_end_i) begin
            st_d.alive = !st_q.skip && (st_q.seen || edge_i);
            st_d.seen  = 1'b0;
            st_d.skip  = 1'b0;
        end else begin
            st_d.seen  = st_q.seen || edge_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign alive_o = st_q.alive;

endmodule

// File: rtl/lane_watch_top.sv
module lane_watch_top
    import lw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lane_a_i,
    input  logic lane_b_i,
    input  logic tx_loop_i,
    input  logic sel_b_i,
    input  logic loop_en_i,
    input  logic word_end_i,
    output logic data_bit_o,
    output logic mon_bit_o,
    output logic alive_o
);

    lw_route_t route;
    logic      chg;
    logic      mon_bit;
    logic      edge_seen;

    assign route.loop_en = loop_en_i;
    assign route.sel_b   = sel_b_i;

    lw_lane_steer u_steer (
        .lane_a_i   (lane_a_i),
        .lane_b_i   (lane_b_i),
        .tx_loop_i  (tx_loop_i),
        .route_i    (route),
        .data_bit_o (data_bit_o),
        .mon_bit_o  (mon_bit)
    );

    lw_ctrl_watch u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .route_i (route),
        .chg_o   (chg)
    );

    lw_edge_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (mon_bit),
        .mask_i (chg),
        .edge_o (edge_seen)
    );

    lw_live_track u_live (
        .clk        (clk),
        .rst        (rst),
        .edge_i     (edge_seen),
        .restart_i  (chg),
        .word_end_i (word_end_i),
        .alive_o    (alive_o)
    );

    assign mon_bit_o = mon_bit;

endmodule

// File: rtl/lw_watch_chk.sv
module lw_watch_chk #(
    parameter int WORD_BITS = 34
) (
    input logic clk,
    input logic rst,
    input logic lane_a_i,
    input logic lane_b_i,
    input logic tx_loop_i,
    input logic sel_b_i,
    input logic loop_en_i,
    input logic word_end_i,
    input logic data_bit_o,
    input logic mon_bit_o,
    input logic alive_o
);

    localparam int CW = $clog2(WORD_BITS);

    // Cycles since the last strobe (or since reset release).
    logic [CW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || word_end_i) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_ROUTE_STRAIGHT: assert property (@(posedge clk) disable iff (rst)
        (!loop_en_i && !sel_b_i) |-> (data_bit_o == lane_a_i && mon_bit_o == lane_b_i)); // R1

    AST_ROUTE_CROSSED: assert property (@(posedge clk) disable iff (rst)
        (!loop_en_i && sel_b_i) |-> (data_bit_o == lane_b_i && mon_bit_o == lane_a_i)); // R2

    AST_ROUTE_LOOP: assert property (@(posedge clk) disable iff (rst)
        loop_en_i |-> (data_bit_o == tx_loop_i && mon_bit_o == tx_loop_i)); // R3

    AST_RISE_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(alive_o) |-> $past(word_end_i)); // R4

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        (!word_end_i && $stable({loop_en_i, sel_b_i})) |=> $stable(alive_o)); // R6

    AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (rst)
        word_end_i |-> (gap_q == CW'(WORD_BITS - 1))); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !alive_o); // R7

    AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !$stable({loop_en_i, sel_b_i}) |=> !alive_o); // R8

endmodule

bind lane_watch_top lw_watch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .lane_a_i   (lane_a_i),
    .lane_b_i   (lane_b_i),
    .tx_loop_i  (tx_loop_i),
    .sel_b_i    (sel_b_i),
    .loop_en_i  (loop_en_i),
    .word_end_i (word_end_i),
    .data_bit_o (data_bit_o),
    .mon_bit_o  (mon_bit_o),
    .alive_o    (alive_o)
);

// File: tb/lane_watch_top_test.sv
module lane_watch_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int WB         = 34;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lane_a = 1'b0, lane_b = 1'b0, tx_bit = 1'b0;
    logic sel = 1'b0, loop_en = 1'b0, word_end = 1'b0;
    logic data_bit, mon_bit, alive;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // Pattern per source: 0 stuck low, 1 toggle, 2 flip at word start,
    // 3 random, 4 single-bit pulse mid-word.
    int a_mode = 3, b_mode = 1, t_mode = 3;

    // Reference model state.
    int    phase = 0;
    int    word_idx = 0;
    int    edges = 0;
    bit    edge_first = 0;
    bit    discard = 1;
    string disc_tag = "R7";
    bit    have_last = 0;
    bit    last_mon = 0;
    bit    [1:0] last_ctrl = 2'b00;
    bit    exp_alive = 0;
    string reason = "R7";

    lane_watch_top uut (
        .clk        (clk),
        .rst        (rst),
        .lane_a_i   (lane_a),
        .lane_b_i   (lane_b),
        .tx_loop_i  (tx_bit),
        .sel_b_i    (sel),
        .loop_en_i  (loop_en),
        .word_end_i (word_end),
        .data_bit_o (data_bit),
        .mon_bit_o  (mon_bit),
        .alive_o    (alive)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic pat_bit(int mode);
        case (mode)
            0:       return 1'b0;
            1:       return cycles[0];
            2:       return word_idx[0];
            3:       return 1'($urandom % 2);
            default: return (phase == 17);
        endcase
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b time=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Drive lane data and the strobe on the falling edge.
    always @(negedge clk) begin
        cycles++;
        lane_a   <= pat_bit(a_mode);
        lane_b   <= pat_bit(b_mode);
        tx_bit   <= pat_bit(t_mode);
        word_end <= (phase == WB - 1);
    end

    // Reference model and comparison, a quarter period after the rising edge.
    always begin
        @(posedge clk);
        #(CLK_PERIOD / 4);
        begin
            logic exp_data, exp_mon;
            bit [1:0] ctrl;
            string rtag;
            ctrl = {loop_en, sel};
            exp_data = loop_en ? tx_bit : (sel ? lane_b : lane_a);
            exp_mon  = loop_en ? tx_bit : (sel ? lane_a : lane_b);
            if (rst) begin
                exp_alive = 0; discard = 1; disc_tag = "R7";
                edges = 0; edge_first = 0; have_last = 0;
                phase = 0; word_idx = 0; reason = "R7";
            end else begin
                if (ctrl != last_ctrl) begin
                    exp_alive = 0; discard = 1; disc_tag = "R8";
                    edges = 0; edge_first = 0; reason = "R8";
                end else begin
                    if (have_last && exp_mon != last_mon) begin
                        edges++;
                        if (phase == 0) edge_first = 1;
                    end
                    if (phase == WB - 1) begin
                        if (discard) begin
                            exp_alive = 0; reason = disc_tag;
                        end else if (edges > 0) begin
                            exp_alive = 1;
                            reason = (edges == 1 && edge_first) ? "R9" : "R4";
                        end else begin
                            exp_alive = 0; reason = "R5";
                        end
                        edges = 0; edge_first = 0; discard = 0;
                    end else begin
                        reason = "R6";
                    end
                end
                have_last = 1;
                if (phase == WB - 1) begin
                    phase = 0;
                    word_idx++;
                end else begin
                    phase++;
                end
            end
            last_mon  = exp_mon;
            last_ctrl = ctrl;
            rtag = loop_en ? "R3" : (sel ? "R2" : "R1");
            if (!rst) begin
                check(rtag, data_bit, exp_data, "data_bit_o");
                check(rtag, mon_bit, exp_mon, "mon_bit_o");
            end
            check(reason, alive, exp_alive, "alive_o");
        end
    end

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        if (cycles > WATCHDOG) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cycles(4);
        rst = 1'b0;
        wait_cycles(WB * 3 + 5);     // R1 routing, R7 then R4 (toggling B)
        b_mode = 0;
        wait_cycles(WB * 3);         // R5 stuck B
        b_mode = 2;
        wait_cycles(WB * 3);         // R9 boundary-only transition
        sel = 1'b1; a_mode = 1;
        wait_cycles(WB * 3 + 11);    // R8 then R2 and R4
        a_mode = 0;
        wait_cycles(WB * 3);         // R5 on crossed route
        loop_en = 1'b1; t_mode = 3;
        wait_cycles(WB * 3);         // R3 loopback, R8
        t_mode = 0;
        wait_cycles(WB * 3);         // R5 in loopback
        sel = 1'b0;
        wait_cycles(WB * 2);         // R3 select ignored in loopback
        loop_en = 1'b0; b_mode = 4;
        wait_cycles(WB * 3 + 7);     // R4 pulse mid-word
        sel = 1'b1;
        wait_cycles(9);
        sel = 1'b0;
        wait_cycles(WB * 3);         // R8 double change
        rst = 1'b1;
        wait_cycles(3);              // R7 reset mid-run
        rst = 1'b0;
        wait_cycles(WB * 3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule